// File: doc/BRIEF.md
# Programmable Interval Timer, Three Channels

This block holds three independent 16-bit down-counters behind a shared byte-wide host port. Each channel advances on its own count-enable strobe while its gate input is high, and drives one output whose shape depends on the programmed mode. A host first writes a control word at offset 3. That word picks a channel, a byte-access order and a mode. The host then loads the initial count through that channel's offset (0, 1 or 2), one or two bytes at a time. The live count, or a frozen copy of it, is read back through the same offsets.

Three output modes are built. The first raises its output once after a single countdown. The second is a periodic rate generator with a one-tick low pulse. The third is a symmetric square wave. Other mode codes and decimal counting are taken as unsupported and park the channel. The read-back command is ignored.

Top module: `pit_timer`

## Requirements
- R1: A write to offset 3 is a control word. Bits 7:6 pick the channel: 0, 1 or 2. The value 3 in those bits is the read-back command, which has no effect on any channel's count, output or byte order.
- R2: Control bits 5:4 set the byte order for the chosen channel's count writes and reads. 1 means low byte only, and the high byte is taken as 0. 2 means high byte only, and the low byte is taken as 0. 3 means the low byte, then the high byte. A new count is loaded into the counter at the clock edge of its last byte.
- R3: Control bits 5:4 equal to 0 form a latch command. It copies the current count into a hold register, and reads return that copy until it has been fully read in the channel's byte order. A second latch command given while a copy is still unread is ignored.
- R4: A control word with a nonzero byte order resets the channel's low/high write and read sequence to the low byte, and drops any held latch copy.
- R5: Mode 0 (bits 3:1 = 000). The output goes low when the control word or a new count is written. It goes high on the tick that brings the count to 0, and it stays high while the count keeps wrapping, until the next load.
- R6: Mode 2 (bits 3:1 = 010). After a load of N ≥ 2 the output is high. It is low for exactly the one tick that takes the count from 2 to 1. On the next tick the count reloads to N and the output goes high, which gives a period of N ticks.
- R7: Mode 3 (bits 3:1 = 011). With a count N ≥ 2, the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeating. The value read back is the number of ticks left in the current half.
- R8: Mode codes 110 and 111 behave exactly as modes 2 and 3.
- R9: Mode codes 001, 100 and 101, and any control word with bit 0 set (decimal counting), are unsupported. The output is held high, and the count neither loads nor changes.
- R10: While a channel's gate is low its count and output do not change on ticks.
- R11: After reset, every output is low, every count reads 0, and the byte sequence starts at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_addr | input | 2 | Offset: 0 to 2 select a channel, 3 the control word |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the offset, valid in the cycle of bus_rd |
| cnt_tick | input | NUM_CH | Per-channel count-enable strobe |
| gate_in | input | NUM_CH | Per-channel gate; low pauses counting |
| tmr_out | output | NUM_CH | Per-channel timer output |

## Verification
Outputs and counts are registered. A tick, a count's last byte or a control word therefore shows its effect at the clock edge that samples it. The bench drives stimulus after a falling edge and samples one time unit after the next rising edge. Read data is combinational on the offset, so it is sampled in the same cycle as bus_rd, before the edge that advances the byte sequence. Periods are measured by holding a strobe high and counting the rising edges until the output changes level. Each half is compared with the tick counts stated in R6 and R7.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RW_LATCH = 2'd0,
    RW_LSB   = 2'd1,
    RW_MSB   = 2'd2,
    RW_BOTH  = 2'd3
  } rw_e;

  typedef enum logic [2:0] {
    MD_IDLE   = 3'd0,
    MD_OFF    = 3'd1,
    MD_ZERO   = 3'd2,
    MD_RATE   = 3'd3,
    MD_SQUARE = 3'd4
  } md_e;

  // Maps the raw mode field and counting-base bit to a built behaviour.
  function automatic md_e decode_mode(input logic [2:0] m, input logic bcd);
    md_e r;
    if (bcd) r = MD_OFF;
    else begin
      case (m)
        3'd0:      r = MD_ZERO;
        3'd2, 3'd6: r = MD_RATE;
        3'd3, 3'd7: r = MD_SQUARE;
        default:   r = MD_OFF;
      endcase
    end
    return r;
  endfunction

  function automatic logic md_supported(input md_e m);
    return (m == MD_ZERO) || (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

  // High half of a square wave: ceil(N/2), with N = 0 standing for 2^CNT_W.
  function automatic logic [CNT_W-1:0] half_hi(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] ext;
    logic [CNT_W:0] sum;
    ext = (n == '0) ? (CNT_W+1)'(1) << CNT_W : {1'b0, n};
    sum = ext + (CNT_W+1)'(1);
    return sum[CNT_W:1];
  endfunction

  // Low half of a square wave: floor(N/2).
  function automatic logic [CNT_W-1:0] half_lo(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] ext;
    ext = (n == '0) ? (CNT_W+1)'(1) << CNT_W : {1'b0, n};
    return ext[CNT_W:1];
  endfunction

  // Builds the loaded count from the last byte and the held low byte.
  function automatic logic [CNT_W-1:0] merge_count(input rw_e rw,
                                                   input logic [BYTE_W-1:0] last,
                                                   input logic [BYTE_W-1:0] hold);
    logic [CNT_W-1:0] r;
    case (rw)
      RW_LSB:  r = {8'h00, last};
      RW_MSB:  r = {last, 8'h00};
      default: r = {last, hold};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pit_cw_decode.sv
module pit_cw_decode
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [NUM_CH-1:0] cw_we,
  output logic [NUM_CH-1:0] latch_we,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] data_rd,
  output rw_e               cw_rw,
  output logic [2:0]        cw_mode,
  output logic              cw_bcd
);
  localparam logic [1:0] CTRL_OFS = 2'd3;

  logic       is_ctrl;
  logic [1:0] sel;

  assign is_ctrl = bus_wr && (bus_addr == CTRL_OFS);
  assign sel     = bus_wdata[7:6];
  assign cw_rw   = rw_e'(bus_wdata[5:4]);
  assign cw_mode = bus_wdata[3:1];
  assign cw_bcd  = bus_wdata[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign cw_we[i]    = is_ctrl && (sel == 2'(i)) && (cw_rw != RW_LATCH);
    assign latch_we[i] = is_ctrl && (sel == 2'(i)) && (cw_rw == RW_LATCH);
    assign data_we[i]  = bus_wr && (bus_addr == 2'(i));
    assign data_rd[i]  = bus_rd && (bus_addr == 2'(i));
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_we,
  input  logic              latch_we,
  input  logic              data_we,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  rw_e               cw_rw,
  input  logic [2:0]        cw_mode,
  input  logic              cw_bcd,
  input  logic              tick,
  input  logic              gate,
  output logic              out,
  output logic [BYTE_W-1:0] rbyte,
  output logic              load_evt,
  output logic              run_evt,
  output logic [2:0]        mode_code
);
  rw_e              rw_q;
  md_e              md_q;
  md_e              md_new;
  logic             wr_hi_q, rd_hi_q;
  logic [BYTE_W-1:0] hold_q;
  logic [CNT_W-1:0] reload_q, cnt_q, latch_q;
  logic             latched_q, armed_q, out_q;

  logic             wr_last;
  logic [CNT_W-1:0] new_val;
  logic [CNT_W-1:0] rd_src;
  logic             rd_hi_sel;
  logic             rd_last;

  assign md_new    = decode_mode(cw_mode, cw_bcd);
  assign wr_last   = data_we && ((rw_q != RW_BOTH) || wr_hi_q);
  assign new_val   = merge_count(rw_q, wdata, hold_q);
  assign load_evt  = wr_last && md_supported(md_q);
  assign run_evt   = tick && gate && armed_q && md_supported(md_q) && !load_evt && !cw_we;
  assign rd_last   = data_rd && ((rw_q != RW_BOTH) || rd_hi_q);

  assign rd_src    = latched_q ? latch_q : cnt_q;
  assign rd_hi_sel = (rw_q == RW_MSB) || ((rw_q == RW_BOTH) && rd_hi_q);
  assign rbyte     = rd_hi_sel ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
  assign out       = out_q;
  assign mode_code = md_q;

  // Host-side byte sequencing and latch copy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw_q      <= RW_BOTH;
      md_q      <= MD_IDLE;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      hold_q    <= '0;
      latched_q <= 1'b0;
      latch_q   <= '0;
    end else if (cw_we) begin
      rw_q      <= cw_rw;
      md_q      <= md_new;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      if (latch_we && !latched_q) begin
        latched_q <= 1'b1;
        latch_q   <= cnt_q;
      end else if (rd_last) begin
        latched_q <= 1'b0;
      end
      if (data_we && (rw_q == RW_BOTH)) begin
        if (!wr_hi_q) hold_q <= wdata;
        wr_hi_q <= !wr_hi_q;
      end
      if (data_rd && (rw_q == RW_BOTH)) rd_hi_q <= !rd_hi_q;
    end
  end

  // Counting core
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      out_q    <= 1'b0;
    end else if (cw_we) begin
      armed_q <= 1'b0;
      out_q   <= (md_new == MD_ZERO) ? 1'b0 : 1'b1;
    end else if (load_evt) begin
      reload_q <= new_val;
      armed_q  <= 1'b1;
      cnt_q    <= (md_q == MD_SQUARE) ? half_hi(new_val) : new_val;
      out_q    <= (md_q == MD_ZERO) ? 1'b0 : 1'b1;
    end else if (run_evt) begin
      case (md_q)
        MD_ZERO: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) out_q <= 1'b1;
        end
        MD_RATE: begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_q <= reload_q;
            out_q <= 1'b1;
          end else if (cnt_q == CNT_W'(2)) begin
            cnt_q <= CNT_W'(1);
            out_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        MD_SQUARE: begin
          if (cnt_q == CNT_W'(1)) begin
            out_q <= !out_q;
            cnt_q <= out_q ? half_lo(reload_q) : half_hi(reload_q);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_CH-1:0] cnt_tick,
  input  logic [NUM_CH-1:0] gate_in,
  output logic [NUM_CH-1:0] tmr_out
);
  localparam int MODE_W = 3;

  logic [NUM_CH-1:0] cw_we, latch_we, data_we, data_rd;
  rw_e               cw_rw;
  logic [2:0]        cw_mode;
  logic              cw_bcd;

  // Named per-channel events, observed by the bound checker
  logic [NUM_CH-1:0]        ch_load;
  logic [NUM_CH-1:0]        ch_run;
  logic [NUM_CH-1:0]        ch_ctrl;
  logic [MODE_W*NUM_CH-1:0] ch_mode;
  logic [BYTE_W-1:0]        ch_rbyte [NUM_CH];

  assign ch_ctrl = cw_we;

  pit_cw_decode #(.NUM_CH(NUM_CH)) u_decode (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cw_we    (cw_we),
    .latch_we (latch_we),
    .data_we  (data_we),
    .data_rd  (data_rd),
    .cw_rw    (cw_rw),
    .cw_mode  (cw_mode),
    .cw_bcd   (cw_bcd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pit_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cw_we    (cw_we[i]),
      .latch_we (latch_we[i]),
      .data_we  (data_we[i]),
      .data_rd  (data_rd[i]),
      .wdata    (bus_wdata),
      .cw_rw    (cw_rw),
      .cw_mode  (cw_mode),
      .cw_bcd   (cw_bcd),
      .tick     (cnt_tick[i]),
      .gate     (gate_in[i]),
      .out      (tmr_out[i]),
      .rbyte    (ch_rbyte[i]),
      .load_evt (ch_load[i]),
      .run_evt  (ch_run[i]),
      .mode_code(ch_mode[MODE_W*i +: MODE_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == 2'(i)) bus_rdata = ch_rbyte[i];
    end
  end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   ch_out,
  input logic [NUM_CH-1:0]   ch_run,
  input logic [NUM_CH-1:0]   ch_load,
  input logic [NUM_CH-1:0]   ch_ctrl,
  input logic [3*NUM_CH-1:0] ch_mode
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    logic [2:0] md;
    assign md = ch_mode[3*i +: 3];

    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_run[i] && !ch_load[i] && !ch_ctrl[i]) |=> $stable(ch_out[i]));

    assert_m0_stays_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 3'(MD_ZERO) && ch_out[i] && !ch_load[i] && !ch_ctrl[i]) |=> ch_out[i]);

    assert_m0_load_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_load[i] && md == 3'(MD_ZERO)) |=> !ch_out[i]);

    assert_ctrl_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_ctrl[i] |=> (ch_out[i] != (md == 3'(MD_ZERO))));

    assert_rate_one_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 3'(MD_RATE) && !ch_out[i] && ch_run[i] && !ch_load[i] && !ch_ctrl[i]) |=> ch_out[i]);

    assert_off_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 3'(MD_OFF)) |-> ch_out[i]);
  end
endmodule

bind pit_timer pit_timer_chk #(.NUM_CH(NUM_CH)) u_pit_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ch_out (tmr_out),
  .ch_run (ch_run),
  .ch_load(ch_load),
  .ch_ctrl(ch_ctrl),
  .ch_mode(ch_mode)
);

// File: tb/test_pit_timer.sv
`timescale 1ns/1ps
module test_pit_timer;
  localparam int NCH = 3;
  localparam int NVEC = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]     bus_addr = '0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [NCH-1:0] cnt_tick = '0;
  logic [NCH-1:0] gate_in = '1;
  logic [NCH-1:0] tmr_out;

  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  pit_timer #(.NUM_CH(NCH)) i_pit_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .gate_in(gate_in), .tmr_out(tmr_out)
  );

  // {control, count, ticks, expected out, expected count}
  localparam logic [55:0] VEC [NVEC] = '{
    {8'h30, 16'd3, 8'd2, 8'd0, 16'd1},      // R5 mode 0 mid count
    {8'h30, 16'd3, 8'd3, 8'd1, 16'd0},      // R5 reaches zero
    {8'h30, 16'd3, 8'd5, 8'd1, 16'hFFFE},   // R5 wraps, stays high
    {8'h74, 16'd4, 8'd3, 8'd0, 16'd1},      // R6 low tick
    {8'h74, 16'd4, 8'd4, 8'd1, 16'd4},      // R6 reload
    {8'h74, 16'd4, 8'd2, 8'd1, 16'd2},      // R6 before pulse
    {8'hB6, 16'd5, 8'd2, 8'd1, 16'd1},      // R7 odd high half
    {8'hB6, 16'd5, 8'd3, 8'd0, 16'd2},      // R7 odd low half
    {8'hB6, 16'd5, 8'd5, 8'd1, 16'd3},      // R7 back high
    {8'hB6, 16'd4, 8'd2, 8'd0, 16'd2},      // R7 even
    {8'h3E, 16'd4, 8'd2, 8'd0, 16'd2},      // R8 code 111 as square
    {8'h3C, 16'd4, 8'd3, 8'd0, 16'd1}       // R8 code 110 as rate
  };

  function automatic string vec_tag(input int i);
    if (i < 3) return "R5";
    if (i < 6) return "R6";
    if (i < 10) return "R7";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cnt_tick[ch] = 1'b1;
      @(posedge clk); #1; cnt_tick[ch] = 1'b0;
    end
  endtask

  task automatic rd16(input int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'(ch), lo);
    rd(2'(ch), hi);
    v = {hi, lo};
  endtask

  task automatic latch16(input int ch, output logic [15:0] v);
    wr(2'd3, {2'(ch), 6'b0});
    rd16(ch, v);
  endtask

  task automatic load16(input int ch, input logic [15:0] n);
    wr(2'(ch), n[7:0]);
    wr(2'(ch), n[15:8]);
  endtask

  // Holds the strobe high and counts ticks until the output leaves 'lvl'
  task automatic measure(input int ch, input logic lvl, output int n);
    n = 0;
    @(negedge clk); cnt_tick[ch] = 1'b1;
    while (n < 70000) begin
      @(posedge clk); #1;
      n++;
      if (tmr_out[ch] != lvl) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    logic [7:0]  b;
    int          n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    check("R11 outputs", 32'(tmr_out), 32'h0);
    rd16(0, v);
    check("R11 count", 32'(v), 32'h0);

    // Vector table: R5..R8
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0]  cw;
      logic [15:0] cnt, ecnt;
      logic [7:0]  nt, eo;
      int          ch;
      {cw, cnt, nt, eo, ecnt} = VEC[i];
      ch = int'(cw[7:6]);
      wr(2'd3, cw);
      load16(ch, cnt);
      ticks(ch, int'(nt));
      check(vec_tag(i), 32'(tmr_out[ch]), 32'(eo[0]));
      latch16(ch, v);
      check(vec_tag(i), 32'(v), 32'(ecnt));
    end

    // R2 low byte only
    wr(2'd3, 8'h10); wr(2'd0, 8'h05); ticks(0, 1);
    wr(2'd3, 8'h00); rd(2'd0, b);
    check("R2 lsb", 32'(b), 32'h04);
    // R2 high byte only
    wr(2'd3, 8'h20); wr(2'd0, 8'h01);
    rd(2'd0, b);
    check("R2 msb load", 32'(b), 32'h01);
    ticks(0, 1); rd(2'd0, b);
    check("R2 msb after tick", 32'(b), 32'h00);

    // R3 latch freeze and ignored second latch
    wr(2'd3, 8'h30); load16(0, 16'd10);
    wr(2'd3, 8'h00); ticks(0, 3);
    wr(2'd3, 8'h00); ticks(0, 1);
    rd16(0, v);
    check("R3 frozen", 32'(v), 32'd10);
    rd16(0, v);
    check("R3 live", 32'(v), 32'd6);

    // R4 control word resets byte sequence
    wr(2'd3, 8'h70); wr(2'd1, 8'h99);
    wr(2'd3, 8'h70); load16(1, 16'd7);
    latch16(1, v);
    check("R4 sequence", 32'(v), 32'd7);
    // R4 control word drops a held latch
    wr(2'd3, 8'h40); ticks(1, 2);
    wr(2'd3, 8'h70); rd16(1, v);
    check("R4 latch drop", 32'(v), 32'd5);

    // R5 new count drives output low again
    wr(2'd3, 8'h30); load16(0, 16'd2); ticks(0, 2);
    check("R5 high", 32'(tmr_out[0]), 32'h1);
    load16(0, 16'd2);
    check("R5 reload low", 32'(tmr_out[0]), 32'h0);

    // R10 gate low pauses
    wr(2'd3, 8'h30); load16(0, 16'd8);
    gate_in[0] = 1'b0; ticks(0, 4);
    check("R10 out", 32'(tmr_out[0]), 32'h0);
    latch16(0, v);
    check("R10 count", 32'(v), 32'd8);
    gate_in[0] = 1'b1; ticks(0, 1);
    latch16(0, v);
    check("R10 resume", 32'(v), 32'd7);

    // R1 read-back control word has no effect
    wr(2'd3, 8'h30); load16(0, 16'd3);
    wr(2'd3, 8'hC2); ticks(0, 1);
    check("R1 out", 32'(tmr_out[0]), 32'h0);
    latch16(0, v);
    check("R1 count", 32'(v), 32'd2);

    // R9 unsupported mode and decimal counting
    wr(2'd3, 8'h32); load16(0, 16'd5);
    check("R9 mode1 out", 32'(tmr_out[0]), 32'h1);
    latch16(0, v); ticks(0, 3); latch16(0, v2);
    check("R9 mode1 count", 32'(v2), 32'(v));
    wr(2'd3, 8'h31); load16(0, 16'd9); ticks(0, 2);
    check("R9 bcd out", 32'(tmr_out[0]), 32'h1);
    latch16(0, v2);
    check("R9 bcd count", 32'(v2), 32'(v));

    // R7 full-scale square wave on channel 0
    wr(2'd3, 8'h36); load16(0, 16'hFFFF);
    measure(0, 1'b1, n); check("R7 full high", 32'(n), 32'd32768);
    measure(0, 1'b0, n); check("R7 full low", 32'(n), 32'd32767);
    cnt_tick[0] = 1'b0;

    // R6 refresh-style pulse on channel 1, low byte only
    wr(2'd3, 8'h54); wr(2'd1, 8'h12);
    measure(1, 1'b1, n); check("R6 first high", 32'(n), 32'd17);
    measure(1, 1'b0, n); check("R6 low width", 32'(n), 32'd1);
    measure(1, 1'b1, n); check("R6 period", 32'(n + 1), 32'd18);
    cnt_tick[1] = 1'b0;

    // R7 odd square wave on channel 2
    wr(2'd3, 8'hB6); load16(2, 16'h0533);
    measure(2, 1'b1, n); check("R7 odd high", 32'(n), 32'd666);
    measure(2, 1'b0, n); check("R7 odd low", 32'(n), 32'd665);
    cnt_tick[2] = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule